// File: doc/BRIEF.md
# Interrupt Request Arbiter and Vector Addresser

This block sits beside the instruction sequencer of a small processor core. It decides which interrupt source is serviced at each instruction boundary and produces the two word addresses used to fetch the service-routine pointer. The pointer table takes the lowest 1 KB of memory and holds 256 entries of four bytes each. The entry for type n begins at byte 4·n. Its low word holds the new instruction pointer and the word at 4·n+2 holds the new code segment.

Sources compete for each boundary in a fixed order:

1. A fault or software interrupt raised by the instruction that just finished.
2. The non-maskable request.
3. The maskable level request.
4. Single-step.

The non-maskable input is edge-captured and held pending, so a short pulse arriving mid-instruction is not lost. A level that stays high is serviced only once. The sequencer drives `boundary_i` for one cycle when an instruction completes. One cycle later it reads `ack_o` together with the registered type and addresses. The bus cycles that fetch the pointer, the stacking of flags and the handshake with an external controller all belong to other blocks.

Top module: `irq_vector_arb`

## Requirements
- R1: While reset is asserted and after its release with no activity, `ack_o` is 0, `type_o` is 0, `ip_addr_o` is 0 and `cs_addr_o` is 2.
- R2: A source is accepted only in a cycle where `boundary_i` is 1. Sources presented with `boundary_i` at 0 produce no acknowledge.
- R3: A boundary with at least one eligible source gives `ack_o` high in the following cycle. The pulse lasts exactly one cycle unless the next boundary also accepts a source.
- R4: `ip_addr_o` equals 4·`type_o` and `cs_addr_o` equals 4·`type_o`+2, as 20-bit byte addresses inside 00000h..003FFh.
- R5: Within the current-instruction group, the order is fixed. Divide error (type 0) wins over a software strobe (type taken from `swi_type_i`), which wins over overflow (type 4). Any member of this group beats every other source.
- R6: A pending non-maskable request beats the maskable request and single-step, and it is reported as type 2 (addresses 00008h and 0000Ah).
- R7: One rising edge of `nmi_i` produces exactly one acknowledge, even if the input stays high across later boundaries. An edge that arrives between boundaries is serviced at the next boundary.
- R8: `intr_i` is level-sensitive and is accepted only while `ie_flag_i` is 1. Its type is `intr_type_i`. With `ie_flag_i` at 0 and no other source, a boundary gives no acknowledge.
- R9: Single-step (`trap_flag_i` at a boundary) has the lowest priority and is reported as type 1.
- R10: `type_o`, `ip_addr_o` and `cs_addr_o` change only in a cycle where `ack_o` is 1, and hold their values otherwise.
- R11: A pending non-maskable request that loses a boundary to a current-instruction source stays pending and is serviced at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_i | input | 1 | Maskable request, level-sensitive |
| intr_type_i | input | 8 | Type supplied with the maskable request |
| swi_stb_i | input | 1 | Software interrupt raised by the finishing instruction |
| swi_type_i | input | 8 | Type operand of the software interrupt |
| exc_div_i | input | 1 | Divide error from the finishing instruction |
| exc_ovf_i | input | 1 | Overflow trap from the finishing instruction |
| trap_flag_i | input | 1 | Single-step flag |
| ie_flag_i | input | 1 | Interrupt-enable flag |
| boundary_i | input | 1 | Current instruction completes this cycle |
| ack_o | output | 1 | Source accepted at the previous boundary |
| type_o | output | 8 | Type of the last accepted source |
| ip_addr_o | output | 20 | Byte address of the instruction-pointer word |
| cs_addr_o | output | 20 | Byte address of the code-segment word |

## Verification
Every result is due exactly one clock after the boundary that accepts a source. This covers the acknowledge, the type and both addresses, since a single register stage separates the decision from the ports. The bench drives stimulus on the falling edge with `boundary_i` high. It samples all outputs on the next falling edge, which falls half a period after the register update, and drops the boundary at that same moment. A non-maskable edge needs one extra clock to reach the pending latch. The bench therefore raises `nmi_i` one falling edge before the boundary it expects to service it.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int TYPE_W = 8;
  localparam logic [TYPE_W-1:0] T_DIV  = 8'd0;
  localparam logic [TYPE_W-1:0] T_STEP = 8'd1;
  localparam logic [TYPE_W-1:0] T_NMI  = 8'd2;
  localparam logic [TYPE_W-1:0] T_OVF  = 8'd4;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_DIV, SRC_SWI, SRC_OVF, SRC_NMI, SRC_INTR, SRC_STEP
  } src_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o,
  output logic rise_o
);
  logic nmi_q, pend_q, pend_d;

  assign rise_o = nmi_i & ~nmi_q;

  always_comb begin
    pend_d = pend_q;
    if (take_i) pend_d = 1'b0;
    if (rise_o) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_vec_pkg::*;
(
  input  logic              boundary_i,
  input  logic              exc_div_i,
  input  logic              swi_stb_i,
  input  logic [TYPE_W-1:0] swi_type_i,
  input  logic              exc_ovf_i,
  input  logic              nmi_pend_i,
  input  logic              intr_i,
  input  logic [TYPE_W-1:0] intr_type_i,
  input  logic              ie_flag_i,
  input  logic              trap_flag_i,
  output logic              take_o,
  output src_e              src_o,
  output logic [TYPE_W-1:0] type_o
);
  always_comb begin
    src_o  = SRC_NONE;
    type_o = '0;
    if (exc_div_i) begin
      src_o = SRC_DIV;  type_o = T_DIV;
    end else if (swi_stb_i) begin
      src_o = SRC_SWI;  type_o = swi_type_i;
    end else if (exc_ovf_i) begin
      src_o = SRC_OVF;  type_o = T_OVF;
    end else if (nmi_pend_i) begin
      src_o = SRC_NMI;  type_o = T_NMI;
    end else if (intr_i && ie_flag_i) begin
      src_o = SRC_INTR; type_o = intr_type_i;
    end else if (trap_flag_i) begin
      src_o = SRC_STEP; type_o = T_STEP;
    end
    take_o = boundary_i && (src_o != SRC_NONE);
  end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [TYPE_W-1:0] type_i,
  output logic [ADDR_W-1:0] ip_addr_o,
  output logic [ADDR_W-1:0] cs_addr_o
);
  localparam int ENTRY_SH = 2;
  localparam int PAD_W    = ADDR_W - TYPE_W - ENTRY_SH;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ip_addr_o = {{PAD_W{1'b0}}, type_i, 2'b00};
      assign cs_addr_o = {{PAD_W{1'b0}}, type_i, 2'b10};
    end else begin : g_nopad
      assign ip_addr_o = {type_i, 2'b00};
      assign cs_addr_o = {type_i, 2'b10};
    end
  endgenerate
endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              intr_i,
  input  logic [7:0]        intr_type_i,
  input  logic              swi_stb_i,
  input  logic [7:0]        swi_type_i,
  input  logic              exc_div_i,
  input  logic              exc_ovf_i,
  input  logic              trap_flag_i,
  input  logic              ie_flag_i,
  input  logic              boundary_i,
  output logic              ack_o,
  output logic [7:0]        type_o,
  output logic [ADDR_W-1:0] ip_addr_o,
  output logic [ADDR_W-1:0] cs_addr_o
);
  logic              take, nmi_pend, nmi_rise, take_nmi;
  src_e              src;
  logic [TYPE_W-1:0] sel_type;
  logic              ack_q, ack_d;
  logic [TYPE_W-1:0] type_q, type_d;

  assign take_nmi = take && (src == SRC_NMI);

  irq_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .take_i(take_nmi),
    .pend_o(nmi_pend), .rise_o(nmi_rise)
  );

  irq_prio_sel u_sel (
    .boundary_i(boundary_i), .exc_div_i(exc_div_i), .swi_stb_i(swi_stb_i),
    .swi_type_i(swi_type_i), .exc_ovf_i(exc_ovf_i), .nmi_pend_i(nmi_pend),
    .intr_i(intr_i), .intr_type_i(intr_type_i), .ie_flag_i(ie_flag_i),
    .trap_flag_i(trap_flag_i), .take_o(take), .src_o(src), .type_o(sel_type)
  );

  always_comb begin
    ack_d  = take;
    type_d = type_q;
    if (take) type_d = sel_type;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      type_q <= '0;
    end else begin
      ack_q  <= ack_d;
      type_q <= type_d;
    end
  end

  irq_vec_addr #(.ADDR_W(ADDR_W)) u_addr (
    .type_i(type_q), .ip_addr_o(ip_addr_o), .cs_addr_o(cs_addr_o)
  );

  assign ack_o  = ack_q;
  assign type_o = type_q;
endmodule

// File: rtl/irq_vector_arb_chk.sv
module irq_vector_arb_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic              exc_div_i,
  input logic              swi_stb_i,
  input logic              exc_ovf_i,
  input logic              intr_i,
  input logic              ie_flag_i,
  input logic              trap_flag_i,
  input logic              nmi_pend,
  input logic              ack_o,
  input logic [7:0]        type_o,
  input logic [ADDR_W-1:0] ip_addr_o,
  input logic [ADDR_W-1:0] cs_addr_o
);
  logic cur_insn, any_src;
  assign cur_insn = exc_div_i || swi_stb_i || exc_ovf_i;
  assign any_src  = cur_insn || nmi_pend || (intr_i && ie_flag_i) || trap_flag_i;

  AST_ACK_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(boundary_i));  // R2
  AST_SOURCE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && any_src |=> ack_o);  // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && !any_src |=> !ack_o);  // R8
  AST_ADDR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_addr_o == ip_addr_o + 2 && ip_addr_o[1:0] == 2'b00 && ip_addr_o < 1024);  // R4
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> $stable(type_o) && $stable(ip_addr_o));  // R10
  AST_DIV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && exc_div_i |=> type_o == 8'd0);  // R5
  AST_NMI_OVER_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && nmi_pend && !cur_insn |=> type_o == 8'd2);  // R6
  AST_NMI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && nmi_pend && cur_insn |=> nmi_pend);  // R11
endmodule

bind irq_vector_arb irq_vector_arb_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .exc_div_i(exc_div_i),
  .swi_stb_i(swi_stb_i), .exc_ovf_i(exc_ovf_i), .intr_i(intr_i),
  .ie_flag_i(ie_flag_i), .trap_flag_i(trap_flag_i), .nmi_pend(nmi_pend),
  .ack_o(ack_o), .type_o(type_o), .ip_addr_o(ip_addr_o), .cs_addr_o(cs_addr_o)
);

// File: tb/irq_vector_arb_tb_top.sv
module irq_vector_arb_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic nmi_i, intr_i, swi_stb_i, exc_div_i, exc_ovf_i, trap_flag_i, ie_flag_i, boundary_i;
  logic [7:0] intr_type_i, swi_type_i;
  logic ack_o;
  logic [7:0] type_o;
  logic [19:0] ip_addr_o, cs_addr_o;
  int n_chk = 0;
  int n_err = 0;
  logic [7:0] last_type;

  always #5 clk = ~clk;

  irq_vector_arb dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .intr_i(intr_i), .intr_type_i(intr_type_i),
    .swi_stb_i(swi_stb_i), .swi_type_i(swi_type_i), .exc_div_i(exc_div_i),
    .exc_ovf_i(exc_ovf_i), .trap_flag_i(trap_flag_i), .ie_flag_i(ie_flag_i),
    .boundary_i(boundary_i), .ack_o(ack_o), .type_o(type_o),
    .ip_addr_o(ip_addr_o), .cs_addr_o(cs_addr_o)
  );

  // {div, swi, swi_type, ovf, intr, intr_type, ie, trap, exp_ack, exp_type}
  function automatic logic [30:0] mk(input logic d, s, input logic [7:0] st,
      input logic o, i, input logic [7:0] it, input logic ie, tr, ea,
      input logic [7:0] et);
    return {d, s, st, o, i, it, ie, tr, ea, et};
  endfunction

  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    mk(1,0,8'h00,0,0,8'h00,0,0,1,8'h00),  // R5 divide alone
    mk(0,1,8'h21,0,0,8'h00,0,0,1,8'h21),  // R5 software type
    mk(0,0,8'h00,1,0,8'h00,0,0,1,8'h04),  // R5 overflow
    mk(0,0,8'h00,0,1,8'h40,1,0,1,8'h40),  // R8 enabled intr
    mk(0,0,8'h00,0,1,8'h77,0,0,0,8'h40),  // R8 masked intr
    mk(0,0,8'h00,0,0,8'h00,0,1,1,8'h01),  // R9 single-step
    mk(0,0,8'h00,0,1,8'h55,1,1,1,8'h55),  // R9 intr beats step
    mk(1,1,8'h33,1,0,8'h00,0,0,1,8'h00),  // R5 div first
    mk(0,1,8'hFF,1,0,8'h00,0,0,1,8'hFF),  // R5 swi over ovf, top entry
    mk(0,0,8'h00,1,1,8'h66,1,1,1,8'h04),  // R5 ovf over intr and step
    mk(0,0,8'h00,0,0,8'h00,1,0,0,8'h04),  // R8 nothing pending
    mk(0,1,8'h05,0,1,8'h90,1,0,1,8'h05)   // R5 swi over intr
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    nmi_i = 0; intr_i = 0; swi_stb_i = 0; exc_div_i = 0; exc_ovf_i = 0;
    trap_flag_i = 0; ie_flag_i = 0; boundary_i = 0; intr_type_i = 0; swi_type_i = 0;
  endtask

  // Sample one falling edge after the boundary is applied.
  task automatic expect_out(input string req, input logic ea, input logic [7:0] et);
    chk({req, " ack"}, 32'(ack_o), 32'(ea));
    chk({req, " type"}, 32'(type_o), 32'(et));
    chk({req, " ip"}, 32'(ip_addr_o), 32'(et) * 4);
    chk({req, " cs"}, 32'(cs_addr_o), 32'(et) * 4 + 2);
  endtask

  task automatic boundary_pulse();
    @(negedge clk); boundary_i = 1;
    @(negedge clk); boundary_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 0, 8'h00);
    rst_n = 1;
    @(negedge clk);
    expect_out("R1 after release", 0, 8'h00);
    last_type = 0;

    for (int k = 0; k < NV; k++) begin
      logic [30:0] v;
      v = VEC[k];
      @(negedge clk);
      exc_div_i = v[30]; swi_stb_i = v[29]; swi_type_i = v[28:21]; exc_ovf_i = v[20];
      intr_i = v[19]; intr_type_i = v[18:11]; ie_flag_i = v[10]; trap_flag_i = v[9];
      boundary_i = 1;
      @(negedge clk);
      if (v[8]) last_type = v[7:0];
      expect_out($sformatf("R4/vec%0d", k), v[8], last_type);
      clear_in();
    end

    // R3: acknowledge is a single pulse
    @(negedge clk);
    chk("R3 pulse ends", 32'(ack_o), 0);
    // R10: outputs hold while idle
    repeat (3) @(negedge clk);
    chk("R10 type held", 32'(type_o), 32'(last_type));

    // R2: source without boundary gives nothing
    exc_div_i = 1; trap_flag_i = 1;
    repeat (3) @(negedge clk);
    chk("R2 no boundary ack", 32'(ack_o), 0);
    chk("R2 no boundary type", 32'(type_o), 32'(last_type));
    clear_in();

    // R7: edge between boundaries, held high, served once
    @(negedge clk); nmi_i = 1;
    repeat (3) @(negedge clk);
    boundary_i = 1;
    @(negedge clk); boundary_i = 0;
    expect_out("R7 first nmi", 1, 8'h02);
    boundary_pulse();
    chk("R7 held level no second ack", 32'(ack_o), 0);
    nmi_i = 0;
    // single-cycle pulse with no boundary, served later
    @(negedge clk); nmi_i = 1;
    @(negedge clk); nmi_i = 0;
    repeat (2) @(negedge clk);
    boundary_pulse();
    chk("R7 short pulse served", 32'(ack_o), 1);

    // R6: NMI beats enabled INTR and step; INTR next
    @(negedge clk); nmi_i = 1; intr_i = 1; intr_type_i = 8'h88; ie_flag_i = 1; trap_flag_i = 1;
    @(negedge clk); boundary_i = 1;
    @(negedge clk); boundary_i = 0;
    expect_out("R6 nmi first", 1, 8'h02);
    boundary_pulse();
    expect_out("R6 intr next", 1, 8'h88);
    clear_in();

    // R11: exception beats pending NMI, NMI kept
    @(negedge clk); nmi_i = 1;
    @(negedge clk); exc_ovf_i = 1; boundary_i = 1;
    @(negedge clk); clear_in(); nmi_i = 1;
    expect_out("R11 ovf wins", 1, 8'h04);
    boundary_pulse();
    expect_out("R11 nmi after", 1, 8'h02);
    clear_in();

    // R1: reset mid-run returns to idle state
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    expect_out("R1 re-reset", 0, 8'h00);
    rst_n = 1;

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule